// File: doc/BRIEF.md
# Sound DSP Host Command Port

This block is the device side of a sound processor's host port on a byte-wide I/O bus. It answers five I/O locations inside a 16-byte window at a fixed base address. These are a reset latch, a command/data write port whose read side reports busy, a response-data port, a response-status port and an acknowledge port for the 16-bit transfer interrupt.

The host puts the block into reset by writing 1 to the reset latch and takes it out by writing 0. After a programmable settling time the block offers the ready byte 0xAA. Command bytes and their arguments arrive one at a time on the write port. A byte parser sorts them into single-byte commands (speaker on, speaker off, version query), a two-argument sample-rate command and a three-argument 16-bit transfer start. The decoded rate, transfer mode and transfer length go to downstream audio and DMA logic on plain outputs. Completion of a transfer is reported back on `dma_done_i` and raises an interrupt that the host clears through the acknowledge port.

Top module: `dsp_host_if`

## Requirements
- R1: After `rst_ni` deasserts, the response-status read (offset 0xE) returns bit 7 = 0, the write-status read (offset 0xC) returns bit 7 = 0, and `irq_o`, `speaker_o`, `rate_o` and `dma_len_o` are 0.
- R2: While the reset latch (offset 0x6, bit 0) holds 1, data-available reads 0 and command writes are discarded. Writing 0 to the latch then queues the byte 0xAA.
- R3: After the releasing write, data-available stays 0 for exactly RESET_DLY response-status reads, one per cycle. The next such read shows bit 7 = 1, and offset 0xA then returns 0xAA.
- R4: Command 0xE1 queues two bytes: VER_MAJOR (default 4) first, then VER_MINOR (default 5).
- R5: A read of offset 0xA while data is available pops one byte. Data-available reads 1 again at once if another byte is still queued, and 0 once the queue is empty.
- R6: An accepted command-port write (offset 0xC) sets busy (bit 7 of the offset 0xC read) for CMD_BUSY cycles. A byte written while busy is dropped.
- R7: Command 0x41 takes two argument bytes, high then low, and loads `rate_o` with {high, low} after the second.
- R8: Command 0xB0 takes a mode byte, then length-minus-one low and high bytes. After the last byte it loads `dma_mode_o` and `dma_len_o` and pulses `dma_start_o` for exactly one cycle.
- R9: A command byte with no defined meaning is consumed with no effect, and the next byte is parsed as a new command.
- R10: Command 0xD1 sets `speaker_o`. Command 0xD3 clears it. Neither takes arguments.
- R11: `dma_done_i` during an active transfer sets `irq_o`, which stays set until a read of offset 0xF clears it. `dma_done_i` with no transfer active has no effect.
- R12: Only addresses BASE_ADDR..BASE_ADDR+0xF are decoded. BASE_ADDR is one of 0x220, 0x240, 0x260 or 0x280. Accesses elsewhere change no state, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational for the addressed port |
| dma_done_i | input | 1 | Transfer-complete pulse from the DMA logic |
| rate_o | output | 16 | Sample rate in Hz |
| dma_mode_o | output | 8 | Mode byte of the last transfer start |
| dma_len_o | output | 16 | Length minus one of the last transfer, in 16-bit samples |
| dma_start_o | output | 1 | One-cycle transfer-start pulse |
| speaker_o | output | 1 | Speaker enable |
| irq_o | output | 1 | Transfer-complete interrupt request |

## Verification
The hardest state to reach from the ports is the window between the releasing reset write and the ready byte becoming visible. Only a host polling the status port on every cycle can measure the length of that window. The bench therefore issues back-to-back single-cycle status reads right after the releasing write, and counts how many of them return not-ready before the first ready. A second hard case is a byte landing while busy is still set. This is reached by writing twice on consecutive cycles without polling, then checking that only the first byte took effect.

// File: rtl/dsp_host_pkg.sv
package dsp_host_pkg;
  typedef enum logic [2:0] {
    PORT_NONE, PORT_RESET, PORT_RDATA, PORT_WCMD, PORT_RSTAT, PORT_ACK16
  } port_e;

  localparam logic [3:0] OFS_RESET = 4'h6;
  localparam logic [3:0] OFS_RDATA = 4'hA;
  localparam logic [3:0] OFS_WCMD  = 4'hC;
  localparam logic [3:0] OFS_RSTAT = 4'hE;
  localparam logic [3:0] OFS_ACK16 = 4'hF;

  localparam logic [7:0] CMD_RATE    = 8'h41;
  localparam logic [7:0] CMD_DMA16   = 8'hB0;
  localparam logic [7:0] CMD_VERSION = 8'hE1;
  localparam logic [7:0] CMD_SPK_ON  = 8'hD1;
  localparam logic [7:0] CMD_SPK_OFF = 8'hD3;

  localparam logic [7:0] READY_BYTE = 8'hAA;
endpackage

// File: rtl/dsp_port_dec.sv
module dsp_port_dec
  import dsp_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h220
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             port_o
);
  logic hit;
  assign hit = (addr_i[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);

  always_comb begin
    port_o = PORT_NONE;
    if (hit) begin
      unique case (addr_i[3:0])
        OFS_RESET: port_o = PORT_RESET;
        OFS_RDATA: port_o = PORT_RDATA;
        OFS_WCMD:  port_o = PORT_WCMD;
        OFS_RSTAT: port_o = PORT_RSTAT;
        OFS_ACK16: port_o = PORT_ACK16;
        default:   port_o = PORT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dsp_out_queue.sv
module dsp_out_queue #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rp_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= push_data_i;
        wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dsp_cmd_parser.sv
module dsp_cmd_parser
  import dsp_host_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] rate_o,
  output logic [7:0]  mode_o,
  output logic [15:0] len_o,
  output logic        start_o,
  output logic        spk_o,
  output logic        ver_req_o
);
  logic [7:0] cmd_q;
  logic [1:0] left_q;
  logic [1:0] idx_q;
  logic [7:0] arg0_q, arg1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; left_q <= '0; idx_q <= '0;
      arg0_q <= '0; arg1_q <= '0;
      rate_o <= '0; mode_o <= '0; len_o <= '0;
      start_o <= 1'b0; spk_o <= 1'b0; ver_req_o <= 1'b0;
    end else if (clr_i) begin
      cmd_q <= '0; left_q <= '0; idx_q <= '0;
      start_o <= 1'b0; spk_o <= 1'b0; ver_req_o <= 1'b0;
    end else begin
      start_o   <= 1'b0;
      ver_req_o <= 1'b0;
      if (byte_vld_i) begin
        if (left_q == '0) begin
          cmd_q <= byte_i;
          idx_q <= '0;
          unique case (byte_i)
            CMD_RATE:    left_q <= 2'd2;
            CMD_DMA16:   left_q <= 2'd3;
            CMD_VERSION: ver_req_o <= 1'b1;
            CMD_SPK_ON:  spk_o <= 1'b1;
            CMD_SPK_OFF: spk_o <= 1'b0;
            default:     ;  // unknown: consumed
          endcase
        end else begin
          left_q <= left_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          if (idx_q == 2'd0) arg0_q <= byte_i;
          if (idx_q == 2'd1) arg1_q <= byte_i;
          if (left_q == 2'd1) begin
            if (cmd_q == CMD_RATE) rate_o <= {arg0_q, byte_i};
            if (cmd_q == CMD_DMA16) begin
              mode_o  <= arg0_q;
              len_o   <= {byte_i, arg1_q};
              start_o <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsp_host_if.sv
module dsp_host_if
  import dsp_host_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h220,
  parameter int unsigned RESET_DLY = 8,
  parameter int unsigned CMD_BUSY  = 2,
  parameter int unsigned Q_DEPTH   = 2,
  parameter logic [7:0]  VER_MAJOR = 8'h04,
  parameter logic [7:0]  VER_MINOR = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              dma_done_i,
  output logic [15:0]       rate_o,
  output logic [7:0]        dma_mode_o,
  output logic [15:0]       dma_len_o,
  output logic              dma_start_o,
  output logic              speaker_o,
  output logic              irq_o
);
  localparam int unsigned HW = $clog2(RESET_DLY + 1);
  localparam int unsigned BW = $clog2(CMD_BUSY + 1);

  port_e         port;
  logic          in_reset_q, minor_pend_q, dma_active_q;
  logic [HW-1:0] hold_q;
  logic [BW-1:0] busy_q;
  logic          busy, avail, q_empty, q_push, q_clr, pop, cmd_acc, ver_req;
  logic          rst_set, rst_rel, ack_rd;
  logic [7:0]    q_head, q_din;

  dsp_port_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(io_addr_i), .port_o(port)
  );

  assign busy    = (busy_q != '0);
  assign avail   = !q_empty && (hold_q == '0);
  assign rst_set = io_wr_i && (port == PORT_RESET) && io_wdata_i[0];
  assign rst_rel = io_wr_i && (port == PORT_RESET) && !io_wdata_i[0] && in_reset_q;
  assign cmd_acc = io_wr_i && (port == PORT_WCMD) && !busy && !in_reset_q;
  assign pop     = io_rd_i && (port == PORT_RDATA) && avail;
  assign ack_rd  = io_rd_i && (port == PORT_ACK16);
  assign q_clr   = rst_set;

  always_comb begin
    q_push = 1'b1;
    if (rst_rel)           q_din = READY_BYTE;
    else if (ver_req)      q_din = VER_MAJOR;
    else if (minor_pend_q) q_din = VER_MINOR;
    else begin
      q_push = 1'b0;
      q_din  = '0;
    end
  end

  dsp_out_queue #(.DEPTH(Q_DEPTH), .W(8)) u_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(q_clr),
    .push_i(q_push), .push_data_i(q_din), .pop_i(pop),
    .head_o(q_head), .empty_o(q_empty)
  );

  dsp_cmd_parser u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rst_set),
    .byte_vld_i(cmd_acc), .byte_i(io_wdata_i),
    .rate_o(rate_o), .mode_o(dma_mode_o), .len_o(dma_len_o),
    .start_o(dma_start_o), .spk_o(speaker_o), .ver_req_o(ver_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_reset_q   <= 1'b0;
      minor_pend_q <= 1'b0;
      dma_active_q <= 1'b0;
      hold_q       <= '0;
      busy_q       <= '0;
      irq_o        <= 1'b0;
    end else if (rst_set) begin
      in_reset_q   <= 1'b1;
      minor_pend_q <= 1'b0;
      dma_active_q <= 1'b0;
      hold_q       <= '0;
      busy_q       <= '0;
      irq_o        <= 1'b0;
    end else begin
      if (rst_rel) begin
        in_reset_q <= 1'b0;
        hold_q     <= HW'(RESET_DLY);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
      if (cmd_acc)   busy_q <= BW'(CMD_BUSY);
      else if (busy) busy_q <= busy_q - 1'b1;
      minor_pend_q <= ver_req;
      // done wins over a same-cycle ack so no completion is lost
      if (dma_done_i && dma_active_q) begin
        irq_o        <= 1'b1;
        dma_active_q <= 1'b0;
      end else begin
        if (ack_rd)      irq_o <= 1'b0;
        if (dma_start_o) dma_active_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (port)
      PORT_RDATA: io_rdata_o = avail ? q_head : 8'h00;
      PORT_RSTAT: io_rdata_o = {avail, 7'h00};
      PORT_WCMD:  io_rdata_o = {busy, 7'h00};
      PORT_ACK16: io_rdata_o = {irq_o, 7'h00};
      default:    io_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/dsp_host_if_chk.sv
module dsp_host_if_chk #(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h220,
  parameter int unsigned RESET_DLY = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic              dma_done_i,
  input logic              dma_start_o,
  input logic              speaker_o,
  input logic [15:0]       rate_o,
  input logic              irq_o,
  input logic              in_reset,
  input logic              avail,
  input logic              busy
);
  localparam int unsigned CW = $clog2(RESET_DLY + 1);
  localparam logic [ADDR_W-1:0] A_RST = BASE_ADDR + ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CMD = BASE_ADDR + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_ACK = BASE_ADDR + ADDR_W'(15);

  logic [CW-1:0] win_q;
  logic wr_rst, wr_cmd, rd_ack;
  assign wr_rst = io_wr_i && (io_addr_i == A_RST);
  assign wr_cmd = io_wr_i && (io_addr_i == A_CMD);
  assign rd_ack = io_rd_i && (io_addr_i == A_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else if (wr_rst && io_wdata_i[0]) win_q <= '0;
    else if (wr_rst && in_reset) win_q <= CW'(RESET_DLY);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  AST_RESET_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reset |-> !avail);  // R2
  AST_READY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> !avail);  // R3
  AST_BUSY_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !busy && !in_reset) |=> busy);  // R6
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && busy) |=> ($stable(speaker_o) && $stable(rate_o)));  // R6
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |=> !dma_start_o);  // R8
  AST_IRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack && !dma_done_i) |=> !irq_o);  // R11
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_ack && !wr_rst) |=> irq_o);  // R11
endmodule

bind dsp_host_if dsp_host_if_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .RESET_DLY(RESET_DLY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
  .io_rd_i(io_rd_i), .io_wdata_i(io_wdata_i), .dma_done_i(dma_done_i),
  .dma_start_o(dma_start_o), .speaker_o(speaker_o), .rate_o(rate_o),
  .irq_o(irq_o), .in_reset(in_reset_q), .avail(avail), .busy(busy)
);

// File: tb/dsp_host_if_bench.sv
module dsp_host_if_bench;
  localparam int unsigned ADDR_W = 10;
  localparam logic [9:0] BASE = 10'h220;
  localparam int unsigned RDLY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [7:0] wdata = '0, rdata, mode;
  logic [15:0] rate, len;
  logic start, spk, irq;
  int tests = 0, fails = 0, starts = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  dsp_host_if #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .RESET_DLY(RDLY),
                .CMD_BUSY(2), .Q_DEPTH(2), .VER_MAJOR(8'h04),
                .VER_MINOR(8'h05)) u_dsp_host_if (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr),
    .io_rd_i(rd), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .dma_done_i(done), .rate_o(rate), .dma_mode_o(mode), .dma_len_o(len),
    .dma_start_o(start), .speaker_o(spk), .irq_o(irq)
  );

  always @(negedge clk) if (start) starts++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic dsp_cmd(logic [7:0] b);
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      bus_rd(BASE + 10'hC, s);
      if (!s[7]) break;
    end
    bus_wr(BASE + 10'hC, b);
  endtask

  // monitor side of the scoreboard: poll, read, compare with expected queue
  task automatic host_read(string req);
    logic [7:0] s, d, e;
    for (int i = 0; i < 50; i++) begin
      bus_rd(BASE + 10'hE, s);
      if (s[7]) break;
    end
    bus_rd(BASE + 10'hA, d);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hXX;
    check(req, {24'h0, d}, {24'h0, e});
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          tests++; fails++;
          $display("FAIL watchdog: actual hung expected done");
          $display("[TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [7:0] s;
    int lows;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    bus_rd(BASE + 10'hE, s); check("R1 rstat", s[7], 0);
    bus_rd(BASE + 10'hC, s); check("R1 wstat", s[7], 0);
    check("R1 irq", irq, 0); check("R1 spk", spk, 0);
    check("R1 rate", rate, 0); check("R1 len", len, 0);

    // R2 reset latch blocks commands
    bus_wr(BASE + 10'h6, 8'h01);
    bus_wr(BASE + 10'hC, 8'hD1);
    repeat (3) @(posedge clk);
    #1 check("R2 cmd ignored in reset", spk, 0);
    bus_rd(BASE + 10'hE, s); check("R2 no data in reset", s[7], 0);
    // R3 release and measure hold window
    bus_wr(BASE + 10'h6, 8'h00);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      bus_rd(BASE + 10'hE, s);
      if (s[7]) break;
      lows++;
    end
    check("R3 hold window", lows, RDLY);
    exp_q.push_back(8'hAA);
    host_read("R3 ready byte");
    bus_rd(BASE + 10'hE, s); check("R5 empty after pop", s[7], 0);

    // R4/R5 version
    exp_q.push_back(8'h04); exp_q.push_back(8'h05);
    dsp_cmd(8'hE1);
    host_read("R4 major");
    bus_rd(BASE + 10'hE, s); check("R5 avail re-raised", s[7], 1);
    host_read("R4 minor");
    bus_rd(BASE + 10'hE, s); check("R5 empty", s[7], 0);

    // R10 speaker
    dsp_cmd(8'hD1); #1 check("R10 on", spk, 1);
    dsp_cmd(8'hD3); #1 check("R10 off", spk, 0);

    // R6 busy and dropped byte
    dsp_cmd(8'hD1);
    bus_rd(BASE + 10'hC, s); check("R6 busy set", s[7], 1);
    dsp_cmd(8'hD3);
    bus_wr(BASE + 10'hC, 8'hD1);  // lands while busy
    repeat (4) @(posedge clk);
    #1 check("R6 busy byte dropped", spk, 0);

    // R7 rate
    dsp_cmd(8'h41); dsp_cmd(8'hAC); dsp_cmd(8'h44);
    #1 check("R7 rate", rate, 16'hAC44);

    // R9 unknown byte then rate
    dsp_cmd(8'h55); dsp_cmd(8'h41); dsp_cmd(8'h2B); dsp_cmd(8'h11);
    #1 check("R9 unknown ignored", rate, 16'h2B11);

    // R11 done without transfer ignored
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    #1 check("R11 idle done ignored", irq, 0);

    // R8 transfer start
    dsp_cmd(8'hB0); dsp_cmd(8'h00); dsp_cmd(8'hFF); dsp_cmd(8'h07);
    repeat (3) @(posedge clk);
    #1 check("R8 mode", mode, 8'h00);
    check("R8 len", len, 16'h07FF);
    check("R8 one start pulse", starts, 1);

    // R11 irq set and held, then ack
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R11 irq held", irq, 1);
    bus_rd(BASE + 10'hF, s);
    #1 check("R11 irq acked", irq, 0);

    // R12 foreign window
    bus_wr(10'h246, 8'h01);
    bus_wr(10'h24C, 8'hD1);
    repeat (4) @(posedge clk);
    #1 check("R12 foreign cmd ignored", spk, 0);
    dsp_cmd(8'hD1); #1 check("R12 not in reset", spk, 1);
    bus_rd(10'h24C, s); check("R12 foreign read zero", s, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule